// File: doc/BRIEF.md
# Dual-Modulus Programmable Frequency Divider

This block divides a fast input clock by a programmable integer. The fast clock is modelled as a clock-enable strobe, `tick`, inside a single synchronous clock domain. A small prescaler counts `tick` pulses and divides by either P+1 or P. Two outer counts steer it. The swallow count A sets how many prescaler periods use the longer modulus. The main count M sets how many prescaler periods make up one full output cycle. One output cycle therefore takes A·(P+1) + (M−A)·P = M·P + A ticks. At the end of each cycle the block emits a single-clock pulse.

The programmed values are taken in only at a cycle boundary, so reprogramming never produces a cycle of mixed length. A combinational error flag reports an illegal setting. While that flag is raised, and while an illegal setting is still running, no output pulses appear. The modulus-control level is brought out so that its pattern can be observed.

Top module: `dual_mod_div`

## Requirements
- R1: Two consecutive `div_pulse` outputs are separated by exactly M·P + A active `tick` cycles, where M and A are the values latched for that output cycle.
- R2: `div_pulse` is registered and lasts one clock. It rises in the clock that follows the edge at which the last tick of the cycle was taken.
- R3: `mod_hi` = 1 selects the P+1 modulus. It is 1 at the start of every output cycle whose A is non-zero, and it stays 1 for exactly A·(P+1) ticks of that cycle.
- R4: After the A-th prescaler period, `mod_hi` = 0 (modulus P) for the remaining (M−A)·P ticks of the cycle.
- R5: `m_cfg` and `a_cfg` are sampled only at reset and at the edge that ends an output cycle. A change made in the middle of a cycle leaves that cycle's length unchanged and applies from the following cycle.
- R6: `cfg_err` is combinational and equals 1 exactly when M < A, M = 0 or A > P−1 on the inputs. No `div_pulse` is issued while it is 1, or while a latched setting with that property is running.
- R7: With M ≥ P−1, every divide ratio from P·(P−1) to the largest value that M and A can encode is produced, with no gaps.
- R8: While `rst` is high, `div_pulse` = 0, all counts are cleared and the inputs are loaded. `mod_hi` then equals (A ≠ 0).
- R9: A clock with `tick` = 0 does not advance any count and cannot produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Fast-clock enable; each high cycle is one input count |
| m_cfg | input | MW | Main count M |
| a_cfg | input | AW | Swallow count A |
| div_pulse | output | 1 | One-clock pulse per full divide cycle |
| mod_hi | output | 1 | Prescaler modulus select: 1 = P+1, 0 = P |
| cfg_err | output | 1 | Illegal M/A setting on the inputs |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. `mod_hi` is read before the rising edge it governs, so each tick is credited to the modulus that was in force when it was taken. A pulse is due one register stage after its completing tick, which means it is seen at the next falling edge. The bench therefore counts ticks up to and including that tick and compares the count with M·P + A and with the high/low split of `mod_hi`. `cfg_err` is combinational, so it is checked at the falling edge on which the illegal value is applied. A reprogrammed ratio is expected only in the interval after the next pulse. All ratios covered by the sweep are collected to confirm there are no gaps.

// File: rtl/dual_mod_div.sv
module dual_mod_div #(
  parameter int P  = 4,
  parameter int MW = 4,
  parameter int AW = $clog2(P)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [MW-1:0] m_cfg,
  input  logic [AW-1:0] a_cfg,
  output logic          div_pulse,
  output logic          mod_hi,
  output logic          cfg_err
);
  localparam int PW = $clog2(P + 1);

  logic [PW-1:0] pc;
  logic [AW-1:0] a_cnt, a_lat;
  logic [MW-1:0] m_cnt, m_lat;
  logic          pulse_q;
  logic          lat_bad, pre_end, cyc_end;

  assign cfg_err = (int'(m_cfg) < int'(a_cfg)) || (m_cfg == '0) || (int'(a_cfg) > P - 1);
  assign lat_bad = (int'(m_lat) < int'(a_lat)) || (m_lat == '0) || (int'(a_lat) > P - 1);
  assign mod_hi  = a_cnt < a_lat;
  assign pre_end = tick && (pc == (mod_hi ? PW'(P) : PW'(P - 1)));
  assign cyc_end = pre_end && (int'(m_cnt) + 1 >= int'(m_lat));
  assign div_pulse = pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      a_cnt   <= '0;
      m_cnt   <= '0;
      m_lat   <= m_cfg;
      a_lat   <= a_cfg;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= cyc_end && !cfg_err && !lat_bad;
      if (tick) pc <= pre_end ? '0 : pc + 1'b1;
      if (cyc_end) begin
        a_cnt <= '0;
        m_cnt <= '0;
        m_lat <= m_cfg;
        a_lat <= a_cfg;
      end else if (pre_end) begin
        m_cnt <= m_cnt + 1'b1;
        if (mod_hi) a_cnt <= a_cnt + 1'b1;
      end
    end
  end

  p_pc_bound_r1: assert property (@(posedge clk) disable iff (rst) int'(pc) <= P);
  p_pulse_after_tick_r9: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(tick));
  p_no_pulse_in_err_r6: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> !$past(cfg_err));
  p_one_clock_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  p_mod_at_start_r3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (mod_hi == (a_lat != '0)));
  p_mod_drop_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(mod_hi)) |-> $past(tick));
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cyc_end)) |-> ($stable(m_lat) && $stable(a_lat)));
endmodule

// File: tb/dual_mod_div_bench.sv
module dual_mod_div_bench;
  localparam int P  = 4;
  localparam int MW = 4;
  localparam int AW = 2;
  localparam int RMAX = ((1 << MW) - 1) * P + P - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [MW-1:0] m_cfg = 4'd1;
  logic [AW-1:0] a_cfg = 2'd0;
  logic div_pulse, mod_hi, cfg_err;

  dual_mod_div #(.P(P), .MW(MW), .AW(AW)) u_dual_mod_div (
    .clk(clk), .rst(rst), .tick(tick), .m_cfg(m_cfg), .a_cfg(a_cfg),
    .div_pulse(div_pulse), .mod_hi(mod_hi), .cfg_err(cfg_err));

  always #4 clk = ~clk;

  int vecs = 0, errs = 0, cyc = 0;
  int cnt, hi, lo, m_cur, a_cur, m_nx, a_nx, seen;
  bit armed = 0, prev_p = 0;
  bit reached [0:RMAX];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit t);
    @(negedge clk);
    if (div_pulse) begin
      chk(!prev_p, "R2 pulse width", 1, 0);
      if (!armed) chk(0, "R6 pulse during error", 1, 0);
      else begin
        chk(cnt == m_cur * P + a_cur, "R1 ticks per pulse", cnt, m_cur * P + a_cur);
        chk(hi == a_cur * (P + 1), "R3 ticks at P+1", hi, a_cur * (P + 1));
        chk(lo == (m_cur - a_cur) * P, "R4 ticks at P", lo, (m_cur - a_cur) * P);
        if (cnt == m_cur * P + a_cur && m_cur >= P - 1) reached[cnt] = 1'b1;
        m_cur = m_nx; a_cur = a_nx;
        seen++;
      end
      cnt = 0; hi = 0; lo = 0;
    end
    prev_p = div_pulse;
    tick = t;
    if (t) begin
      cnt++;
      if (mod_hi) hi++; else lo++;
    end
  endtask

  task automatic do_reset(input int m, input int a);
    @(negedge clk);
    rst = 1'b1; tick = 1'b0;
    m_cfg = MW'(m); a_cfg = AW'(a);
    @(negedge clk);
    @(negedge clk);
    chk(div_pulse == 1'b0, "R8 pulse in reset", int'(div_pulse), 0);
    chk(mod_hi == (a != 0), "R8 modulus after reset", int'(mod_hi), int'(a != 0));
    rst = 1'b0;
    cnt = 0; hi = 0; lo = 0; seen = 0; prev_p = 0;
    m_cur = m; a_cur = a; m_nx = m; a_nx = a; armed = 1;
  endtask

  task automatic run_pulses(input int n, input bit gap);
    for (int i = 0; i < 400 * n && seen < n; i++) step(gap ? ((i % 3) != 1) : 1'b1);
    chk(seen >= n, "R1 pulses observed", seen, n);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; vecs++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r <= RMAX; r++) reached[r] = 1'b0;
    // R8 reset state, then full sweep (R1, R3, R4, R7)
    for (int m = 1; m < (1 << MW); m++)
      for (int a = 0; a < P; a++)
        if (a <= m) begin
          do_reset(m, a);
          run_pulses(2, (m + a) % 2 == 1);
        end
    for (int r = P * (P - 1); r <= RMAX; r++)
      chk(reached[r], "R7 ratio reachable", int'(reached[r]), 1);

    // R9: tick held low, no pulse and no progress
    do_reset(2, 1);
    run_pulses(1, 1'b0);
    for (int i = 0; i < 60; i++) step(1'b0);
    chk(seen == 1, "R9 no pulse without tick", seen, 1);
    run_pulses(3, 1'b0);

    // R5: change mid-cycle applies from the following cycle
    do_reset(5, 2);
    run_pulses(1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1);
    m_cfg = 4'd3; a_cfg = 2'd1; m_nx = 3; a_nx = 1;
    run_pulses(4, 1'b0);
    chk(m_cur == 3, "R5 new ratio in force", m_cur, 3);

    // R6: illegal settings flag and suppress pulses
    do_reset(6, 1);
    run_pulses(1, 1'b0);
    @(negedge clk);
    m_cfg = 4'd1; a_cfg = 2'd3; armed = 0;
    #1 chk(cfg_err == 1'b1, "R6 error M<A", int'(cfg_err), 1);
    for (int i = 0; i < 120; i++) step(1'b1);
    m_cfg = 4'd0; a_cfg = 2'd0;
    #1 chk(cfg_err == 1'b1, "R6 error M=0", int'(cfg_err), 1);
    for (int i = 0; i < 40; i++) step(1'b1);
    m_cfg = 4'd3; a_cfg = 2'd3;
    #1 chk(cfg_err == 1'b0, "R6 error clear at M=A", int'(cfg_err), 0);
    do_reset(3, 3);
    run_pulses(2, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule